// File: doc/BRIEF.md
# PS/2 Keyboard Command Sender

This block lets a host issue keyboard commands over the two open-collector PS/2 wires and follow the keyboard's answers. A request is a 3-bit opcode plus an optional argument byte, handed over on a valid/ready pair. The block holds the clock line low to inhibit the keyboard and then signals a request to send. After that it shifts out a framed byte on the keyboard-generated clock and checks the keyboard's acknowledge bit. It then waits for the reply byte, which a separate PS/2 receiver delivers. For the two-byte commands (LED setting, repeat rate) it sends the argument only after the first byte is answered with FA.

The pads are driven only through output enables: an enable of 1 pulls the line low and an enable of 0 releases it, so the line is never driven high. A request is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the cycle in which `done` pulses. A requester that sees `cmd_ready` low keeps its opcode and argument stable and holds `cmd_valid` until they are taken. Received bytes carry no ready signal, because the keyboard cannot be stalled; the block ignores a byte it is not waiting for.

Opcodes: 0 sets the LEDs (ED + argument), 1 is echo (EE), 2 sets the repeat rate (F3 + argument), 3 is resend (FE), 4 is reset (FF). Status codes on `done`: 0 OK, 1 TIMEOUT, 2 NOACK, 3 BAD.

Top module: `ps2_cmd_host`

## Requirements
- R1: After reset both line enables are 0, `cmd_ready` is 1 and `done` is 0.
- R2: A request is accepted when `cmd_valid` and `cmd_ready` are high at a clock edge. `cmd_ready` is then low until `done` pulses, and `done` pulses in a cycle where `cmd_ready` is high again.
- R3: Each transfer holds the clock low with data released for at least INHIBIT_CYC cycles. It then pulls data low while the clock is still low, and only then releases the clock.
- R4: Each byte goes out on the keyboard clock falling edges as eight data bits, least significant first. They are followed by an odd parity bit (the nine bits together hold an odd number of ones) and a released, high stop bit.
- R5: If data is high at the eleventh keyboard clock falling edge (no acknowledge bit), the command ends with status 2 (NOACK).
- R6: Opcode 1 sends byte EE and ends with status 0 when the reply byte is EE.
- R7: Opcodes 0 and 2 send ED or F3, wait for reply FA, then send the argument byte. They end with status 0 only after a second FA.
- R8: Opcode 3 sends FE, accepts any reply byte with status 0, and shows that byte on `reply`. Opcode 4 sends FF and ends with status 0 on reply FA.
- R9: A reply byte other than the expected one ends the command with status 3 (BAD), and no further byte is sent.
- R10: If no keyboard clock falling edge arrives within START_TO_CYC cycles of the clock release or of the previous edge, the command ends with status 1 (TIMEOUT) and both lines are released.
- R11: If no reply byte arrives within REPLY_TO_CYC cycles after an acknowledged byte, the command ends with status 1 (TIMEOUT).
- R12: Opcodes 5 to 7 end with status 3 without pulling either line low.
- R13: A received byte that arrives while no command is in progress causes no `done` and leaves `cmd_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle, request can be taken |
| cmd_op | input | 3 | Request opcode (0 to 4 valid) |
| cmd_arg | input | 8 | Argument byte for opcodes 0 and 2 |
| rx_valid | input | 1 | One-cycle strobe of a byte from the PS/2 receiver |
| rx_data | input | 8 | Received byte |
| ps2_clk_i | input | 1 | Sensed level of the PS/2 clock line |
| ps2_data_i | input | 1 | Sensed level of the PS/2 data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_data_oe | output | 1 | 1 pulls the data line low |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Outcome, valid with `done` |
| reply | output | 8 | Last reply byte taken from the receiver |

## Verification
The hardest state to reach from the ports is the middle of a two-byte command. Here the block is waiting for FA before the argument, and a wrong reply, a missing acknowledge bit or silence has to be injected at exactly that point. The bench contains a behavioural keyboard that watches the wired-AND lines for the request-to-send pattern. It generates the eleven clocks, samples each bit on the rising edge and chooses whether to pull data low for the acknowledge. A scripted reply strobe then plays the receiver, so each failure can be placed after any chosen byte. The argument byte is swept over all LED patterns and a spread of rate values, and the frame parity and bit order are computed arithmetically in the bench.

// File: rtl/ps2_cmd_pkg.sv
package ps2_cmd_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_NOACK   = 2'd2,
    ST_BAD     = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    OP_LEDS   = 3'd0,
    OP_ECHO   = 3'd1,
    OP_RATE   = 3'd2,
    OP_RESEND = 3'd3,
    OP_RESET  = 3'd4
  } op_e;

  localparam logic [7:0] KB_SET_LEDS = 8'hED;
  localparam logic [7:0] KB_ECHO     = 8'hEE;
  localparam logic [7:0] KB_RATE     = 8'hF3;
  localparam logic [7:0] KB_RESEND   = 8'hFE;
  localparam logic [7:0] KB_RESET    = 8'hFF;
  localparam logic [7:0] KB_ACK      = 8'hFA;

  // Number of keyboard clock falling edges in one host-to-device transfer
  localparam int FRAME_EDGES = 11;

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line,
  input  logic data_line,
  output logic data_s,
  output logic clk_fall
);

  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_pipe <= '1;
      dat_pipe <= '1;
      clk_prev <= 1'b1;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], clk_line};
      dat_pipe <= {dat_pipe[STAGES-2:0], data_line};
      clk_prev <= clk_pipe[STAGES-1];
    end
  end

  assign data_s   = dat_pipe[STAGES-1];
  assign clk_fall = clk_prev & ~clk_pipe[STAGES-1];

endmodule

// File: rtl/ps2_tx_phy.sv
module ps2_tx_phy
  import ps2_cmd_pkg::*;
#(
  parameter int INHIBIT_CYC  = 5000,
  parameter int START_TO_CYC = 750000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       kb_fall,
  input  logic       kb_data,
  output logic       clk_oe,
  output logic       data_oe,
  output logic       busy,
  output logic       fin,
  output status_e    fin_res
);

  localparam int TMAX = (INHIBIT_CYC > START_TO_CYC) ? INHIBIT_CYC : START_TO_CYC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(FRAME_EDGES + 1);

  typedef enum logic [1:0] {P_IDLE, P_INH, P_REQ, P_SHIFT} pst_e;

  pst_e           st;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [9:0]     frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= P_IDLE;
      cnt     <= '0;
      idx     <= '0;
      frame   <= '0;
      clk_oe  <= 1'b0;
      data_oe <= 1'b0;
      fin     <= 1'b0;
      fin_res <= ST_OK;
    end else begin
      fin <= 1'b0;
      unique case (st)
        P_IDLE: begin
          if (start) begin
            frame  <= {1'b1, ~^tx_byte, tx_byte};
            cnt    <= '0;
            clk_oe <= 1'b1;
            st     <= P_INH;
          end
        end
        P_INH: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(INHIBIT_CYC - 1)) begin
            data_oe <= 1'b1;
            st      <= P_REQ;
          end
        end
        P_REQ: begin
          clk_oe <= 1'b0;
          cnt    <= '0;
          idx    <= '0;
          st     <= P_SHIFT;
        end
        P_SHIFT: begin
          if (kb_fall) begin
            cnt <= '0;
            if (idx < IW'(FRAME_EDGES - 1)) begin
              data_oe <= ~frame[0];
              frame   <= {1'b0, frame[9:1]};
              idx     <= idx + 1'b1;
            end else begin
              data_oe <= 1'b0;
              fin     <= 1'b1;
              fin_res <= kb_data ? ST_NOACK : ST_OK;
              st      <= P_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(START_TO_CYC - 1)) begin
              clk_oe  <= 1'b0;
              data_oe <= 1'b0;
              fin     <= 1'b1;
              fin_res <= ST_TIMEOUT;
              st      <= P_IDLE;
            end
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  assign busy = (st != P_IDLE);

endmodule

// File: rtl/ps2_cmd_seq.sv
module ps2_cmd_seq
  import ps2_cmd_pkg::*;
#(
  parameter int REPLY_TO_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_arg,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       phy_start,
  output logic [7:0] phy_byte,
  input  logic       phy_fin,
  input  status_e    phy_res,
  output logic       done,
  output status_e    status,
  output logic [7:0] reply
);

  localparam int RW = $clog2(REPLY_TO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT, S_REJ} sst_e;

  sst_e          st;
  op_e           op_q;
  logic [7:0]    arg_q;
  logic          second;
  logic [RW-1:0] rcnt;

  logic          has_arg;
  logic          any_ok;
  logic [7:0]    want;
  logic [7:0]    first_byte;

  always_comb begin
    has_arg    = (op_q == OP_LEDS) || (op_q == OP_RATE);
    any_ok     = (op_q == OP_RESEND);
    want       = (op_q == OP_ECHO) ? KB_ECHO : KB_ACK;
    unique case (cmd_op)
      OP_LEDS:   first_byte = KB_SET_LEDS;
      OP_ECHO:   first_byte = KB_ECHO;
      OP_RATE:   first_byte = KB_RATE;
      OP_RESEND: first_byte = KB_RESEND;
      default:   first_byte = KB_RESET;
    endcase
  end

  assign cmd_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= OP_ECHO;
      arg_q     <= '0;
      second    <= 1'b0;
      rcnt      <= '0;
      phy_start <= 1'b0;
      phy_byte  <= '0;
      done      <= 1'b0;
      status    <= ST_OK;
      reply     <= '0;
    end else begin
      phy_start <= 1'b0;
      done      <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            if (cmd_op > 3'd4) begin
              st <= S_REJ;
            end else begin
              op_q      <= op_e'(cmd_op);
              arg_q     <= cmd_arg;
              second    <= 1'b0;
              phy_byte  <= first_byte;
              phy_start <= 1'b1;
              st        <= S_TX;
            end
          end
        end
        S_REJ: begin
          done   <= 1'b1;
          status <= ST_BAD;
          st     <= S_IDLE;
        end
        S_TX: begin
          if (phy_fin) begin
            if (phy_res != ST_OK) begin
              done   <= 1'b1;
              status <= phy_res;
              st     <= S_IDLE;
            end else begin
              rcnt <= '0;
              st   <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (rx_valid) begin
            reply <= rx_data;
            if (!any_ok && rx_data != want) begin
              done   <= 1'b1;
              status <= ST_BAD;
              st     <= S_IDLE;
            end else if (has_arg && !second) begin
              second    <= 1'b1;
              phy_byte  <= arg_q;
              phy_start <= 1'b1;
              st        <= S_TX;
            end else begin
              done   <= 1'b1;
              status <= ST_OK;
              st     <= S_IDLE;
            end
          end else begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == RW'(REPLY_TO_CYC - 1)) begin
              done   <= 1'b1;
              status <= ST_TIMEOUT;
              st     <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ps2_cmd_host.sv
module ps2_cmd_host
  import ps2_cmd_pkg::*;
#(
  parameter int INHIBIT_CYC  = 5000,
  parameter int START_TO_CYC = 750000,
  parameter int REPLY_TO_CYC = 1000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_arg,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       ps2_clk_oe,
  output logic       ps2_data_oe,
  output logic       done,
  output logic [1:0] status,
  output logic [7:0] reply
);

  logic       kb_fall;
  logic       kb_data;
  logic       phy_start;
  logic [7:0] phy_byte;
  logic       phy_busy;
  logic       phy_fin;
  status_e    phy_res;
  status_e    seq_status;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_line (ps2_clk_i),
    .data_line(ps2_data_i),
    .data_s   (kb_data),
    .clk_fall (kb_fall)
  );

  ps2_tx_phy #(
    .INHIBIT_CYC (INHIBIT_CYC),
    .START_TO_CYC(START_TO_CYC)
  ) u_phy (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (phy_start),
    .tx_byte(phy_byte),
    .kb_fall(kb_fall),
    .kb_data(kb_data),
    .clk_oe (ps2_clk_oe),
    .data_oe(ps2_data_oe),
    .busy   (phy_busy),
    .fin    (phy_fin),
    .fin_res(phy_res)
  );

  ps2_cmd_seq #(.REPLY_TO_CYC(REPLY_TO_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_arg  (cmd_arg),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .phy_start(phy_start),
    .phy_byte (phy_byte),
    .phy_fin  (phy_fin),
    .phy_res  (phy_res),
    .done     (done),
    .status   (seq_status),
    .reply    (reply)
  );

  assign status = seq_status;

endmodule

// File: rtl/ps2_cmd_host_chk.sv
module ps2_cmd_host_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic ps2_clk_oe,
  input logic ps2_data_oe,
  input logic done
);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!ps2_clk_oe && !ps2_data_oe));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R2
  return_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> done);

  // R3
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> ps2_data_oe);

endmodule

bind ps2_cmd_host ps2_cmd_host_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .ps2_clk_oe (ps2_clk_oe),
  .ps2_data_oe(ps2_data_oe),
  .done       (done)
);

// File: tb/ps2_cmd_host_bench.sv
module ps2_cmd_host_bench;

  localparam int INH = 20;
  localparam int STO = 400;
  localparam int RTO = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_arg = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       ps2_clk_oe, ps2_data_oe;
  logic       done;
  logic [1:0] status;
  logic [7:0] reply;
  logic       kb_clk_drv = 1'b0;
  logic       kb_dat_drv = 1'b0;
  logic       line_clk, line_dat;

  assign line_clk = !(ps2_clk_oe || kb_clk_drv);
  assign line_dat = !(ps2_data_oe || kb_dat_drv);

  always #5 clk = ~clk;

  ps2_cmd_host #(.INHIBIT_CYC(INH), .START_TO_CYC(STO), .REPLY_TO_CYC(RTO)) u_ps2_cmd_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rx_valid(rx_valid), .rx_data(rx_data),
    .ps2_clk_i(line_clk), .ps2_data_i(line_dat), .ps2_clk_oe(ps2_clk_oe),
    .ps2_data_oe(ps2_data_oe), .done(done), .status(status), .reply(reply)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic       done_seen = 0;
  logic [1:0] got_status = 0;
  int         inh_run = 0;
  int         inh_len = 0;
  bit         clk_seen = 0;

  always @(negedge clk) begin
    if (done) begin
      done_seen  <= 1'b1;
      got_status <= status;
    end
    if (ps2_clk_oe) clk_seen <= 1'b1;
    if (ps2_clk_oe && !ps2_data_oe) inh_run <= inh_run + 1;
    else if (ps2_clk_oe && ps2_data_oe && inh_run != 0) begin
      inh_len <= inh_run;
      inh_run <= 0;
    end else if (!ps2_clk_oe) inh_run <= 0;
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [7:0] arg);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    done_seen = 0;
    clk_seen  = 0;
    cmd_op    = op;
    cmd_arg   = arg;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic kb_frame(input bit give_ack, output logic [7:0] b, output bit ok);
    logic [9:0] bits;
    while (!(!line_clk && !line_dat)) @(negedge clk);
    while (!line_clk) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      repeat (5) @(negedge clk);
      kb_clk_drv = 1'b1;
      repeat (10) @(negedge clk);
      kb_clk_drv = 1'b0;
      bits[i] = line_dat;
    end
    repeat (5) @(negedge clk);
    kb_dat_drv = give_ack;
    repeat (2) @(negedge clk);
    kb_clk_drv = 1'b1;
    repeat (10) @(negedge clk);
    kb_clk_drv = 1'b0;
    repeat (2) @(negedge clk);
    kb_dat_drv = 1'b0;
    b  = bits[7:0];
    ok = (bits[9] == 1'b1) && ((^bits[8:0]) == 1'b1);
  endtask

  task automatic send_reply(input logic [7:0] v);
    repeat (30) @(negedge clk);
    rx_data  = v;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_done;
    int n = 0;
    while (!done_seen && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic frame_check(input string req, input logic [7:0] exp_b, input bit ack);
    logic [7:0] b;
    bit ok;
    kb_frame(ack, b, ok);
    check(b == exp_b, req, b, exp_b);
    check(ok, "R4 parity/stop", ok, 1);
    check(inh_len >= INH, "R3 inhibit length", inh_len, INH);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!ps2_clk_oe && !ps2_data_oe, "R1 lines", {ps2_clk_oe, ps2_data_oe}, 0);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    check(done == 1'b0, "R1 done", done, 0);

    // R13 stray byte while idle
    done_seen = 0;
    send_reply(8'hFA);
    repeat (20) @(negedge clk);
    check(!done_seen && cmd_ready, "R13 stray byte", done_seen, 0);

    // R6 echo, R2 busy
    send_cmd(3'd1, 8'h00);
    check(!cmd_ready, "R2 busy after accept", cmd_ready, 0);
    frame_check("R6 echo byte", 8'hEE, 1'b1);
    send_reply(8'hEE);
    wait_done();
    check(done_seen && got_status == 2'd0, "R6 echo status", got_status, 0);
    check(cmd_ready, "R2 ready after done", cmd_ready, 1);

    // R7 LED sweep
    for (int v = 0; v < 8; v++) begin
      send_cmd(3'd0, 8'(v));
      frame_check("R7 led cmd", 8'hED, 1'b1);
      send_reply(8'hFA);
      frame_check("R7 led arg", 8'(v), 1'b1);
      send_reply(8'hFA);
      wait_done();
      check(done_seen && got_status == 2'd0, "R7 led status", got_status, 0);
    end

    // R7 rate sweep, R4 bit order on varied bytes
    for (int k = 0; k < 32; k++) begin
      logic [7:0] rv;
      rv = 8'((k * 37 + 5) % 256);
      send_cmd(3'd2, rv);
      frame_check("R7 rate cmd", 8'hF3, 1'b1);
      send_reply(8'hFA);
      frame_check("R4 rate arg", rv, 1'b1);
      send_reply(8'hFA);
      wait_done();
      check(done_seen && got_status == 2'd0, "R7 rate status", got_status, 0);
    end

    // R8 resend
    send_cmd(3'd3, 8'h00);
    frame_check("R8 resend byte", 8'hFE, 1'b1);
    send_reply(8'h5A);
    wait_done();
    check(done_seen && got_status == 2'd0, "R8 resend status", got_status, 0);
    check(reply == 8'h5A, "R8 reply byte", reply, 8'h5A);

    // R8 reset
    send_cmd(3'd4, 8'h00);
    frame_check("R8 reset byte", 8'hFF, 1'b1);
    send_reply(8'hFA);
    wait_done();
    check(done_seen && got_status == 2'd0, "R8 reset status", got_status, 0);

    // R5 missing acknowledge bit
    send_cmd(3'd1, 8'h00);
    frame_check("R5 echo byte", 8'hEE, 1'b0);
    wait_done();
    check(done_seen && got_status == 2'd2, "R5 noack status", got_status, 2);

    // R9 wrong echo reply
    send_cmd(3'd1, 8'h00);
    frame_check("R9 echo byte", 8'hEE, 1'b1);
    send_reply(8'hFA);
    wait_done();
    check(done_seen && got_status == 2'd3, "R9 bad echo", got_status, 3);

    // R9 wrong first reply on LED command, no argument sent
    send_cmd(3'd0, 8'h07);
    frame_check("R9 led cmd", 8'hED, 1'b1);
    send_reply(8'hFE);
    wait_done();
    check(done_seen && got_status == 2'd3, "R9 bad led reply", got_status, 3);
    clk_seen = 0;
    repeat (200) @(negedge clk);
    check(!clk_seen, "R9 no further byte", clk_seen, 0);

    // R10 keyboard silent
    send_cmd(3'd1, 8'h00);
    wait_done();
    check(done_seen && got_status == 2'd1, "R10 start timeout", got_status, 1);
    check(!ps2_clk_oe && !ps2_data_oe, "R10 lines released", {ps2_clk_oe, ps2_data_oe}, 0);

    // R11 no reply byte
    send_cmd(3'd4, 8'h00);
    frame_check("R11 reset byte", 8'hFF, 1'b1);
    wait_done();
    check(done_seen && got_status == 2'd1, "R11 reply timeout", got_status, 1);

    // R12 unknown opcodes
    for (int op = 5; op < 8; op++) begin
      send_cmd(3'(op), 8'h00);
      wait_done();
      check(done_seen && got_status == 2'd3, "R12 reject status", got_status, 3);
      check(!clk_seen && !ps2_data_oe, "R12 bus untouched", clk_seen, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule